// File: doc/BRIEF.md
# Sigma-Delta Filter Enable Controller

This block holds the enable state of a multi-channel sigma-delta filter peripheral and turns it into run signals for every input channel and every filter. A master enable gates eight channel enables and four filter enables. A channel or filter runs only while its own bit and the master bit are both set. Whenever a filter starts running, the block pulses a reinitialisation strobe to that filter's sinc stage and integrator stage. Whenever a filter stops running, it pulses clear strobes to that filter's interrupt-status and watchdog-status registers. No other configuration is touched.

Software programs the enables through a small write port. The power controller asks through a stop request whether the peripheral clock may be gated. Gating is acknowledged only after the master enable has been cleared and every filter bit is zero. A request made while the master enable is still set is flagged as an error.

Top module: `sdf_enable_ctrl`

## Requirements
- R1: After reset all enable bits are zero, and every run, strobe, acknowledge and error output is low.
- R2: A write with wrEn high at the clock edge decodes wrAddr as follows:
  - 0: the master enable takes wrData bit 0.
  - 1: the channel enables take wrData bits 7:0, bit i for channel i.
  - 2: the filter enables take wrData bits 3:0, bit i for filter i.
  - 3: the write changes no state and no output.
- R3: chRun[i] is high exactly when channel enable i and the master enable are both set. It follows a write in the cycle right after the write's clock edge.
- R4: filtRun[i] is high exactly when filter enable i and the master enable are both set. Clearing the filter's bit drops filtRun[i] in the cycle right after the write edge.
- R5: When filtRun[i] rises, sincReinit[i] and integReinit[i] pulse high for exactly one cycle, starting one cycle after the rise. This holds whether the filter bit or the master bit caused the rise.
- R6: When filtRun[i] falls, statusClr[i] and wdogStatusClr[i] pulse high for exactly one cycle, starting one cycle after the fall. Filters whose run signal did not change get no strobe.
- R7: Clearing the master enable forces all chRun and filtRun low in the next cycle. The stored channel and filter bits are kept, and they reappear on the run outputs when the master enable is set again.
- R8: clkGateAck is high in the cycle after an edge at which stopReq was high, the master enable was clear and all filter bits were clear.
- R9: stopErr is high, with clkGateAck low, in the cycle after an edge at which stopReq was high while the master enable was set.
- R10: A stop request with the master enable clear but some filter bit set gives neither clkGateAck nor stopErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe of the configuration port |
| wrAddr | input | 2 | Configuration write address |
| wrData | input | 8 | Configuration write data |
| stopReq | input | 1 | Request to gate the peripheral clock |
| chRun | output | 8 | Effective run per channel |
| filtRun | output | 4 | Effective run per filter |
| sincReinit | output | 4 | One-cycle reinit pulse to each filter's sinc stage |
| integReinit | output | 4 | One-cycle reinit pulse to each filter's integrator |
| statusClr | output | 4 | One-cycle clear pulse to each filter's interrupt status |
| wdogStatusClr | output | 4 | One-cycle clear pulse to each filter's watchdog status |
| clkGateAck | output | 1 | Clock gating permitted |
| stopErr | output | 1 | Stop requested while the master enable is set |

## Verification
A corrupted enable bit appears on the run outputs in the cycle after the write that should have set it. It also appears after any later master-enable toggle, because that toggle restores the stored bits to the run outputs. A faulty edge detector shows up one cycle after a run transition, as a missing, doubled or misplaced reinit or clear pulse on the wrong filter. A broken stop check shows up in the cycle after the request as a wrong acknowledge or error. The bench therefore compares every output on every cycle against a model built from the requirements.

// File: rtl/sdf_en_pkg.sv
package sdf_en_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MASTER = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CHAN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FILT   = 2'd2;

  // decoded register write strobes from control to datapath
  typedef struct packed {
    logic wrMaster;
    logic wrChan;
    logic wrFilt;
  } wrStrobe_t;
endpackage

// File: rtl/sdf_en_ctrl.sv
module sdf_en_ctrl
  import sdf_en_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              stopReq,
  input  logic              masterEn,
  input  logic              filtEnAny,
  output wrStrobe_t         strb,
  output logic              clkGateAck,
  output logic              stopErr
);

  // address decode; any other address is dropped
  always_comb begin
    strb          = '0;
    strb.wrMaster = wrEn && (wrAddr == ADDR_MASTER);
    strb.wrChan   = wrEn && (wrAddr == ADDR_CHAN);
    strb.wrFilt   = wrEn && (wrAddr == ADDR_FILT);
  end

  logic gateOk;
  logic gateBad;
  assign gateOk  = stopReq && !masterEn && !filtEnAny;
  assign gateBad = stopReq && masterEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkGateAck <= 1'b0;
      stopErr    <= 1'b0;
    end else begin
      clkGateAck <= gateOk;
      stopErr    <= gateBad;
    end
  end

  // R9: request with master enable set yields error, not acknowledge
  a_r9_err_on_master: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && masterEn) |=> (stopErr && !clkGateAck));

  // R10: a filter bit still set blocks the acknowledge
  a_r10_filter_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && filtEnAny) |=> !clkGateAck);

  // R8: acknowledge and error never together
  a_r8_ack_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(clkGateAck && stopErr));
endmodule

// File: rtl/sdf_en_regs.sv
module sdf_en_regs
  import sdf_en_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_FILT = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic                masterEn,
  output logic                filtEnAny,
  output logic [NUM_CH-1:0]   chRun,
  output logic [NUM_FILT-1:0] filtRun
);

  logic [NUM_CH-1:0]   chEn;
  logic [NUM_FILT-1:0] filtEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              masterEn <= 1'b0;
    else if (strb.wrMaster) masterEn <= wrData[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            chEn[c] <= 1'b0;
      else if (strb.wrChan) chEn[c] <= wrData[c];
    end
    assign chRun[c] = chEn[c] && masterEn;
  end

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            filtEn[f] <= 1'b0;
      else if (strb.wrFilt) filtEn[f] <= wrData[f];
    end
    assign filtRun[f] = filtEn[f] && masterEn;

    // R4: clearing the filter bit stops the filter on the next cycle
    a_r4_abort_now: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrFilt && !wrData[f]) |=> !filtRun[f]);
  end

  assign filtEnAny = |filtEn;

  // R7: clearing the master enable silences every run signal
  a_r7_master_off: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMaster && !wrData[0]) |=> (chRun == '0 && filtRun == '0));

  // R2: no write strobe, no change in run outputs
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(chRun) && $stable(filtRun)));
endmodule

// File: rtl/sdf_en_edge.sv
module sdf_en_edge (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic reinitPulse,
  output logic clearPulse
);

  logic runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ        <= 1'b0;
      reinitPulse <= 1'b0;
      clearPulse  <= 1'b0;
    end else begin
      runQ        <= run;
      reinitPulse <= run && !runQ;
      clearPulse  <= !run && runQ;
    end
  end

  // R5: a start always brings a reinit pulse one cycle later
  a_r5_reinit_follows: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |=> reinitPulse);

  // R5: pulse lasts a single cycle
  a_r5_reinit_single: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |=> !reinitPulse);

  // R6: a stop always brings a status clear one cycle later
  a_r6_clear_follows: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |=> clearPulse);

  // R6: clear and reinit never coincide
  a_r6_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(clearPulse && reinitPulse));
endmodule

// File: rtl/sdf_enable_ctrl.sv
module sdf_enable_ctrl
  import sdf_en_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_FILT = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                stopReq,
  output logic [NUM_CH-1:0]   chRun,
  output logic [NUM_FILT-1:0] filtRun,
  output logic [NUM_FILT-1:0] sincReinit,
  output logic [NUM_FILT-1:0] integReinit,
  output logic [NUM_FILT-1:0] statusClr,
  output logic [NUM_FILT-1:0] wdogStatusClr,
  output logic                clkGateAck,
  output logic                stopErr
);

  wrStrobe_t strb;
  logic      masterEn;
  logic      filtEnAny;

  sdf_en_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .stopReq   (stopReq),
    .masterEn  (masterEn),
    .filtEnAny (filtEnAny),
    .strb      (strb),
    .clkGateAck(clkGateAck),
    .stopErr   (stopErr)
  );

  sdf_en_regs #(
    .NUM_CH  (NUM_CH),
    .NUM_FILT(NUM_FILT),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .masterEn (masterEn),
    .filtEnAny(filtEnAny),
    .chRun    (chRun),
    .filtRun  (filtRun)
  );

  logic [NUM_FILT-1:0] reinitP;
  logic [NUM_FILT-1:0] clearP;

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_edge
    sdf_en_edge u_edge (
      .clk        (clk),
      .rstN       (rstN),
      .run        (filtRun[f]),
      .reinitPulse(reinitP[f]),
      .clearPulse (clearP[f])
    );
  end

  assign sincReinit    = reinitP;
  assign integReinit   = reinitP;
  assign statusClr     = clearP;
  assign wdogStatusClr = clearP;
endmodule

// File: tb/sdf_enable_ctrl_tb.sv
module sdf_enable_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       stopReq = 1'b0;
  logic [7:0] chRun;
  logic [3:0] filtRun, sincReinit, integReinit, statusClr, wdogStatusClr;
  logic       clkGateAck, stopErr;

  always #5 clk = ~clk;

  sdf_enable_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stopReq(stopReq), .chRun(chRun), .filtRun(filtRun),
    .sincReinit(sincReinit), .integReinit(integReinit),
    .statusClr(statusClr), .wdogStatusClr(wdogStatusClr),
    .clkGateAck(clkGateAck), .stopErr(stopErr)
  );

  typedef struct {
    logic [7:0] ch;
    logic [3:0] fr;
    logic [3:0] re;
    logic [3:0] cl;
    logic       ack;
    logic       err;
    string      tag;
  } exp_t;

  exp_t queueExp[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  // reference model state
  logic       mMaster = 0;
  logic [7:0] mCh = 0;
  logic [3:0] mFilt = 0;
  logic [3:0] runPrev = 0, runPrev2 = 0;

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic stop, input string tag);
    exp_t e;
    logic oldMaster;
    logic [3:0] oldFilt, runNew;
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; stopReq = stop;
    oldMaster = mMaster; oldFilt = mFilt;
    if (we && a == 2'd0) mMaster = d[0];
    if (we && a == 2'd1) mCh = d;
    if (we && a == 2'd2) mFilt = d[3:0];
    runNew = mFilt & {4{mMaster}};
    e.ch  = mCh & {8{mMaster}};
    e.fr  = runNew;
    e.re  = runPrev & ~runPrev2;
    e.cl  = ~runPrev & runPrev2;
    e.ack = stop && !oldMaster && (oldFilt == 0);
    e.err = stop && oldMaster;
    e.tag = tag;
    runPrev2 = runPrev;
    runPrev  = runNew;
    queueExp.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expectation per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (queueExp.size() > 0) begin
        exp_t e;
        e = queueExp.pop_front();
        cmp(e.tag, "chRun", chRun, e.ch);
        cmp(e.tag, "filtRun", {4'b0, filtRun}, {4'b0, e.fr});
        cmp(e.tag, "sincReinit", {4'b0, sincReinit}, {4'b0, e.re});
        cmp(e.tag, "integReinit", {4'b0, integReinit}, {4'b0, e.re});
        cmp(e.tag, "statusClr", {4'b0, statusClr}, {4'b0, e.cl});
        cmp(e.tag, "wdogStatusClr", {4'b0, wdogStatusClr}, {4'b0, e.cl});
        cmp(e.tag, "clkGateAck", {7'b0, clkGateAck}, {7'b0, e.ack});
        cmp(e.tag, "stopErr", {7'b0, stopErr}, {7'b0, e.err});
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    cmp("R1", "chRun", chRun, 8'h00);
    cmp("R1", "outs", {filtRun, sincReinit}, 8'h00);
    cmp("R1", "clr", {statusClr, wdogStatusClr}, 8'h00);
    cmp("R1", "stop", {6'b0, clkGateAck, stopErr}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    step(0, 0, 8'h00, 0, "R1 idle");
    step(1, 1, 8'hA5, 0, "R3 channel bits with master off");
    step(1, 2, 8'h05, 0, "R4 filter bits with master off");
    step(0, 0, 8'h00, 1, "R10 stop with filter bit set");
    step(0, 0, 8'h00, 0, "R10 settle");
    step(1, 0, 8'h01, 0, "R7 master on");
    step(0, 0, 8'h00, 0, "R5 reinit after master rise");
    step(0, 0, 8'h00, 0, "R5 single pulse");
    step(1, 3, 8'hFF, 0, "R2 reserved address ignored");
    step(0, 0, 8'h00, 0, "R2 still ignored");
    step(1, 1, 8'h3C, 0, "R3 channel rewrite");
    step(1, 2, 8'h07, 0, "R5 filter1 enable");
    step(0, 0, 8'h00, 0, "R5 filter1 reinit");
    step(0, 0, 8'h00, 0, "R5 quiet");
    step(1, 2, 8'h03, 0, "R4 filter2 abort");
    step(0, 0, 8'h00, 0, "R6 filter2 clear");
    step(0, 0, 8'h00, 1, "R9 stop while master on");
    step(0, 0, 8'h00, 0, "R9 release");
    step(1, 0, 8'h00, 0, "R7 master off");
    step(0, 0, 8'h00, 0, "R6 clear after master off");
    step(1, 0, 8'h01, 0, "R7 bits retained");
    step(0, 0, 8'h00, 0, "R5 reinit after master back");
    step(1, 2, 8'h08, 0, "R5 R6 swap filters");
    step(0, 0, 8'h00, 0, "R5 R6 swap pulses");
    step(1, 0, 8'h00, 0, "R7 master off again");
    step(1, 2, 8'h00, 1, "R10 stop with filter still set");
    step(0, 0, 8'h00, 1, "R8 stop when idle");
    step(0, 0, 8'h00, 1, "R8 stop held");
    step(0, 0, 8'h00, 0, "R8 release");
    step(0, 0, 8'h00, 0, "R8 idle");

    @(negedge clk);
    wait (queueExp.size() == 0);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule